// File: doc/BRIEF.md
# Accumulator Micro-ALU with Condition Flags

This block is the register-only execution unit of a small 8-bit accumulator machine. It holds an accumulator (A), an index register (X), a high index byte (H) and a six-bit condition-code register with overflow (V), half-carry (H), interrupt mask (I), negative (N), zero (Z) and carry (C) bits. On a start strobe it takes one opcode byte together with up to two immediate operand bytes. It then stays busy for the instruction's fixed cycle count, commits the new register and flag values, and pulses done.

The supported operations are increment, logical shift left, logical shift right, unsigned 8x8 multiply, and immediate loads of A, X or the H:X pair. Each operation has its own rule for which flags it updates, clears or leaves alone. An opcode outside the supported set retires in one cycle with no state change and raises an illegal-opcode pulse. Memory addressing, stack, branching and instruction fetch are handled elsewhere.

Top module: `accu_exec`

## Requirements
- R1: After reset, regA, regX and regH are 0x00, ccr is 0x08 (I set, all other flags clear), and busy and done are low. The ccr bit order is {V,H,I,N,Z,C}, with V at bit 5 and C at bit 0.
- R2: A start with busy low is accepted. busy stays high until done pulses high for exactly one cycle, N clock edges after the accepting edge. N is 1 for increment, shift and unknown opcodes, 2 for single-byte loads, 3 for the pair load and 5 for multiply. A start seen while busy is ignored.
- R3: Opcode 0x4C increments A and opcode 0x5C increments X, wrapping modulo 256. V is set only when the result is 0x80. N copies result bit 7 and Z is set when the result is zero. C and H are unchanged.
- R4: Opcode 0x48 shifts A left by one and opcode 0x58 shifts X left by one, with 0 entering bit 0. C takes the old bit 7, N takes the new bit 7, Z flags a zero result, V = N XOR C, and H is unchanged.
- R5: Opcode 0x44 shifts A right by one and opcode 0x54 shifts X right by one, with 0 entering bit 7. C takes the old bit 0, N is forced to 0, Z flags a zero result, V equals the new C, and H is unchanged.
- R6: Opcode 0x42 forms the 16-bit unsigned product X*A. The high byte goes to X and the low byte to A. The H flag and C are cleared, while V, N and Z are left unchanged, even when the product is zero.
- R7: Opcode 0xA6 loads A from opFirst and opcode 0xAE loads X from opFirst. V is cleared, N and Z follow the loaded byte, and C and H are unchanged.
- R8: Opcode 0x45 loads H from opFirst and X from opSecond. V is cleared, N takes opFirst bit 7, and Z is set only when all 16 bits are zero.
- R9: Any other opcode changes no register or flag, and illegal pulses high together with done.
- R10: Registers and flags change only in a cycle where done is high, and no operation alters the I flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to execute the presented opcode |
| opcode | input | 8 | Opcode byte, sampled when start is accepted |
| opFirst | input | 8 | First immediate byte (single-byte load value, or high byte of the pair load) |
| opSecond | input | 8 | Second immediate byte (low byte of the pair load) |
| busy | output | 1 | High while an accepted operation is in progress |
| done | output | 1 | One-cycle pulse in the cycle the results become visible |
| illegal | output | 1 | One-cycle pulse with done for an unknown opcode |
| regA | output | 8 | Accumulator |
| regX | output | 8 | Index register |
| regH | output | 8 | High index byte |
| ccr | output | 6 | Condition flags {V,H,I,N,Z,C} |

## Verification
A chained sequence of operations is run, each starting from the state the previous one left behind, so the results depend on the value flowing through. Some operands sit at the boundaries that make flags diverge: an increment crossing 0x7F to 0x80 and wrapping 0xFF to 0x00, a left shift of 0x80 that produces a zero result with carry, and right shifts of odd and zero values. A multiply with a nonzero high byte checks that the product is split correctly, and a multiply with a zero product checks that Z is held rather than updated. Pair loads of 0x0000 and 0x8001 tell the 16-bit zero and sign rules apart from the 8-bit ones. An unknown opcode, and a start raised during a multiply, confirm that nothing moves when it should not.

// File: rtl/accu_pkg.sv
package accu_pkg;
  localparam int DW   = 8;   // datapath byte width
  localparam int CNTW = 3;   // width of the latency counter

  typedef enum logic [3:0] {
    K_INC_A, K_INC_X, K_LSL_A, K_LSL_X, K_LSR_A, K_LSR_X,
    K_MUL, K_LD_A, K_LD_X, K_LD_HX, K_BAD
  } opKind_t;

  // control -> datapath strobes
  typedef struct packed {
    logic capture;
    logic commit;
  } ctlStrobe_t;

  // condition flags, V in the top bit, C in the bottom bit
  typedef struct packed {
    logic v;
    logic h;
    logic i;
    logic n;
    logic z;
    logic c;
  } ccr_t;

  function automatic opKind_t decodeOp(input logic [7:0] op);
    case (op)
      8'h4C:   return K_INC_A;
      8'h5C:   return K_INC_X;
      8'h48:   return K_LSL_A;
      8'h58:   return K_LSL_X;
      8'h44:   return K_LSR_A;
      8'h54:   return K_LSR_X;
      8'h42:   return K_MUL;
      8'hA6:   return K_LD_A;
      8'hAE:   return K_LD_X;
      8'h45:   return K_LD_HX;
      default: return K_BAD;
    endcase
  endfunction

  function automatic logic [CNTW-1:0] opCycles(input opKind_t k);
    case (k)
      K_MUL:         return CNTW'(5);
      K_LD_HX:       return CNTW'(3);
      K_LD_A, K_LD_X: return CNTW'(2);
      default:       return CNTW'(1);
    endcase
  endfunction
endpackage

// File: rtl/accu_ctrl.sv
module accu_ctrl
  import accu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] opcode,
  output logic       busy,
  output logic       done,
  output logic       illegal,
  output ctlStrobe_t strobe
);
  localparam logic [CNTW-1:0] ONE = CNTW'(1);

  logic [CNTW-1:0] remain;
  logic            badOp;
  logic            accept;
  opKind_t         kindIn;

  assign kindIn         = decodeOp(opcode);
  assign accept         = start && !busy;
  assign strobe.capture = accept;
  assign strobe.commit  = busy && (remain == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      illegal <= 1'b0;
      remain  <= '0;
      badOp   <= 1'b0;
    end else begin
      done    <= strobe.commit;
      illegal <= strobe.commit && badOp;
      if (accept) begin
        busy   <= 1'b1;
        remain <= opCycles(kindIn) - ONE;
        badOp  <= (kindIn == K_BAD);
      end else if (busy) begin
        if (remain == '0) busy <= 1'b0;
        else              remain <= remain - ONE;
      end
    end
  end
endmodule

// File: rtl/accu_dpath.sv
module accu_dpath
  import accu_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    strobe,
  input  logic [7:0]    opcode,
  input  logic [DW-1:0] opFirst,
  input  logic [DW-1:0] opSecond,
  output logic [DW-1:0] regA,
  output logic [DW-1:0] regX,
  output logic [DW-1:0] regH,
  output logic [5:0]    ccr
);
  localparam logic [DW-1:0] SIGN_ONLY = {1'b1, {(DW-1){1'b0}}};

  opKind_t         kindQ;
  logic [DW-1:0]   hiQ, loQ;
  ccr_t            flags, nFlags;
  logic [DW-1:0]   nA, nX, nH;
  logic            selX;
  logic [DW-1:0]   src, incR, lslR, lsrR;
  logic [2*DW-1:0] prod;

  assign ccr  = flags;
  assign selX = (kindQ == K_INC_X) || (kindQ == K_LSL_X) || (kindQ == K_LSR_X);
  assign src  = selX ? regX : regA;
  assign incR = src + DW'(1);
  assign lslR = {src[DW-2:0], 1'b0};
  assign lsrR = {1'b0, src[DW-1:1]};
  assign prod = {{DW{1'b0}}, regX} * {{DW{1'b0}}, regA};

  always_comb begin
    nA     = regA;
    nX     = regX;
    nH     = regH;
    nFlags = flags;
    case (kindQ)
      K_INC_A, K_INC_X: begin
        if (selX) nX = incR; else nA = incR;
        nFlags.v = (incR == SIGN_ONLY);
        nFlags.n = incR[DW-1];
        nFlags.z = (incR == '0);
      end
      K_LSL_A, K_LSL_X: begin
        if (selX) nX = lslR; else nA = lslR;
        nFlags.c = src[DW-1];
        nFlags.n = lslR[DW-1];
        nFlags.z = (lslR == '0);
        nFlags.v = lslR[DW-1] ^ src[DW-1];
      end
      K_LSR_A, K_LSR_X: begin
        if (selX) nX = lsrR; else nA = lsrR;
        nFlags.c = src[0];
        nFlags.n = 1'b0;
        nFlags.z = (lsrR == '0);
        nFlags.v = src[0];
      end
      K_MUL: begin
        nX       = prod[2*DW-1:DW];
        nA       = prod[DW-1:0];
        nFlags.h = 1'b0;
        nFlags.c = 1'b0;
      end
      K_LD_A, K_LD_X: begin
        if (kindQ == K_LD_X) nX = hiQ; else nA = hiQ;
        nFlags.v = 1'b0;
        nFlags.n = hiQ[DW-1];
        nFlags.z = (hiQ == '0);
      end
      K_LD_HX: begin
        nH       = hiQ;
        nX       = loQ;
        nFlags.v = 1'b0;
        nFlags.n = hiQ[DW-1];
        nFlags.z = ({hiQ, loQ} == '0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ <= K_BAD;
      hiQ   <= '0;
      loQ   <= '0;
      regA  <= '0;
      regX  <= '0;
      regH  <= '0;
      flags <= '{v: 1'b0, h: 1'b0, i: 1'b1, n: 1'b0, z: 1'b0, c: 1'b0};
    end else begin
      if (strobe.capture) begin
        kindQ <= decodeOp(opcode);
        hiQ   <= opFirst;
        loQ   <= opSecond;
      end
      if (strobe.commit) begin
        regA  <= nA;
        regX  <= nX;
        regH  <= nH;
        flags <= nFlags;
      end
    end
  end
endmodule

// File: rtl/accu_exec.sv
module accu_exec
  import accu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic [7:0] opcode,
  input  logic [7:0] opFirst,
  input  logic [7:0] opSecond,
  output logic       busy,
  output logic       done,
  output logic       illegal,
  output logic [7:0] regA,
  output logic [7:0] regX,
  output logic [7:0] regH,
  output logic [5:0] ccr
);
  ctlStrobe_t strobe;

  accu_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .busy(busy), .done(done), .illegal(illegal), .strobe(strobe)
  );

  accu_dpath i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opcode(opcode),
    .opFirst(opFirst), .opSecond(opSecond),
    .regA(regA), .regX(regX), .regH(regH), .ccr(ccr)
  );
endmodule

// File: rtl/accu_exec_chk.sv
module accu_exec_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic [7:0] opcode,
  input logic [7:0] opFirst,
  input logic [7:0] opSecond,
  input logic       busy,
  input logic       done,
  input logic       illegal,
  input logic [7:0] regA,
  input logic [7:0] regX,
  input logic [7:0] regH,
  input logic [5:0] ccr
);
  // R2: done lasts a single cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: an idle start is accepted
  p_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R9: illegal only alongside done
  p_illegal_done_r9: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> done);

  // R9: unknown opcode leaves all state alone
  p_illegal_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> ($stable(regA) && $stable(regX) && $stable(regH) && $stable(ccr)));

  // R10: state moves only with done
  p_commit_only_r10: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(regA) && $stable(regX) && $stable(regH) && $stable(ccr)));

  // R10: interrupt mask stays set
  p_imask_r10: assert property (@(posedge clk) disable iff (!rstN)
    ccr[3]);
endmodule

bind accu_exec accu_exec_chk i_chk (.*);

// File: tb/test_accu_exec.sv
`timescale 1ns/1ps
module test_accu_exec;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0] opcode = 8'h00, opFirst = 8'h00, opSecond = 8'h00;
  logic busy, done, illegal;
  logic [7:0] regA, regX, regH;
  logic [5:0] ccr;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  accu_exec i_accu_exec (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .opFirst(opFirst), .opSecond(opSecond), .busy(busy), .done(done),
    .illegal(illegal), .regA(regA), .regX(regX), .regH(regH), .ccr(ccr)
  );

  typedef struct packed {
    logic [23:0] tag;
    logic [7:0]  op;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [7:0]  expA;
    logic [7:0]  expX;
    logic [7:0]  expH;
    logic [5:0]  expCcr;
    logic [2:0]  cyc;
    logic        bad;
  } vec_t;

  // ccr = {V,H,I,N,Z,C}; each row starts from the state the row above leaves
  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{"R7 ", 8'hA6, 8'h7F, 8'h00, 8'h7F, 8'h00, 8'h00, 6'h08, 3'd2, 1'b0},
    '{"R3 ", 8'h4C, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00, 6'h2C, 3'd1, 1'b0}, // 7F->80 sets V
    '{"R4 ", 8'h48, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 6'h2B, 3'd1, 1'b0}, // 80<<1: C,Z,V
    '{"R7 ", 8'hAE, 8'h81, 8'h00, 8'h00, 8'h81, 8'h00, 6'h0D, 3'd2, 1'b0}, // C kept
    '{"R5 ", 8'h54, 8'h00, 8'h00, 8'h00, 8'h40, 8'h00, 6'h29, 3'd1, 1'b0}, // odd >>1
    '{"R4 ", 8'h58, 8'h00, 8'h00, 8'h00, 8'h80, 8'h00, 6'h2C, 3'd1, 1'b0},
    '{"R7 ", 8'hA6, 8'h03, 8'h00, 8'h03, 8'h80, 8'h00, 6'h08, 3'd2, 1'b0},
    '{"R6 ", 8'h42, 8'h00, 8'h00, 8'h80, 8'h01, 8'h00, 6'h08, 3'd5, 1'b0}, // 0x80*3
    '{"R4 ", 8'h48, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 6'h2B, 3'd1, 1'b0},
    '{"R6 ", 8'h42, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 6'h2A, 3'd5, 1'b0}, // C cleared, Z held
    '{"R8 ", 8'h45, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 6'h0A, 3'd3, 1'b0},
    '{"R8 ", 8'h45, 8'h80, 8'h01, 8'h00, 8'h01, 8'h80, 6'h0C, 3'd3, 1'b0},
    '{"R3 ", 8'h5C, 8'h00, 8'h00, 8'h00, 8'h02, 8'h80, 6'h08, 3'd1, 1'b0},
    '{"R5 ", 8'h44, 8'h00, 8'h00, 8'h00, 8'h02, 8'h80, 6'h0A, 3'd1, 1'b0}, // zero >>1
    '{"R7 ", 8'hAE, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h80, 6'h0C, 3'd2, 1'b0},
    '{"R3 ", 8'h5C, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80, 6'h0A, 3'd1, 1'b0}, // FF wraps, C untouched
    '{"R9 ", 8'h9D, 8'h12, 8'h34, 8'h00, 8'h00, 8'h80, 6'h0A, 3'd1, 1'b1},
    '{"R3 ", 8'h4C, 8'h00, 8'h00, 8'h01, 8'h00, 8'h80, 6'h08, 3'd1, 1'b0}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Presents one operation and returns the number of edges until done.
  task automatic runOp(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                       output int lat);
    @(negedge clk);
    opcode = op; opFirst = a; opSecond = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "regA", regA, 8'h00);
    check("R1", "regX", regX, 8'h00);
    check("R1", "regH", regH, 8'h00);
    check("R1", "ccr", ccr, 6'h08);
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    rstN = 1'b1;

    for (int k = 0; k < NV; k++) begin
      string t;
      t = string'(VECS[k].tag);
      runOp(VECS[k].op, VECS[k].a, VECS[k].b, lat);
      check("R2", "latency", lat, VECS[k].cyc);
      check(t, "regA", regA, VECS[k].expA);
      check(t, "regX", regX, VECS[k].expX);
      check(t, "regH", regH, VECS[k].expH);
      check(t, "ccr", ccr, VECS[k].expCcr);
      check("R9", "illegal", illegal, VECS[k].bad);
    end

    // R2: done is a one-cycle pulse
    @(negedge clk);
    check("R2", "done after pulse", done, 0);
    check("R2", "busy idle", busy, 0);

    // R2: start while a multiply is busy is ignored (A=01, X=00 before)
    @(negedge clk);
    opcode = 8'h42; start = 1'b1;
    @(negedge clk);
    opcode = 8'hA6; opFirst = 8'h55;   // held high for one busy cycle
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check("R2", "mul latency with stray start", lat, 5);
    check("R6", "regA zero product", regA, 8'h00);
    check("R6", "regX zero product", regX, 8'h00);
    check("R6", "ccr Z held", ccr, 6'h08);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      check("R2", "no second done", done, 0);
      check("R10", "regA steady", regA, 8'h00);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule